// File: doc/BRIEF.md
# Key-Unlocked Protected Control Register Bank

This block is a bank of byte-wide system control registers on a plain byte bus. The bus has an address, write data, a write strobe, a read strobe and read data. The registers fall into three groups:

- **Guarded window:** a small group of registers that software should change only on purpose.
- **Key register:** the register that opens the guarded window.
- **Open window:** a group of registers that can be written at any time, such as per-port pull-up enables.

A write to the guarded window lands only while the key register holds the unlock value 0x96. Any other key value closes the window again. A write that is refused is dropped without any error indication.

Software opens the bank by writing 0x96 to the key register. It then changes as many guarded registers as it needs, one byte per bus cycle. Finally it writes any other value to the key register to close the window. Reads never depend on the key, and a read of any unmapped address returns 0x00. What each control bit does downstream is handled outside this block.

Top module: `keyed_ctl_bank`

## Requirements
- R1: After reset every register, including the key register, holds 0x00, so the guarded window starts closed. `rdata` is 0x00 during and after reset.
- R2: `rdata` is registered. In the cycle after a cycle with `rd_en` high, it shows the contents of the addressed register as they were before any write in that same cycle. In the cycle after a cycle with `rd_en` low, it is 0x00.
- R3: A read of any address that maps to no register returns 0x00. This includes the odd addresses between 0x010 and 0x01B.
- R4: The key register at address 0x020 can always be written and read back.
- R5: The guarded registers sit at the even addresses 0x010, 0x012, 0x014, 0x016, 0x018 and 0x01A. A write to one of them takes effect when the key register already held 0x96 at the start of that cycle.
- R6: A write to a guarded register while the key register is not 0x96 is discarded, and the register keeps its old value.
- R7: The window stays open across any number of guarded writes. It closes only when the key register is written with a value other than 0x96.
- R8: The thirteen open-window bytes at addresses 0x C41 through 0xC4D accept writes whatever the key value is.
- R9: Reads of every register return its contents whether the window is open or closed, and a read changes no register.
- R10: A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Byte address of the access |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |

## Verification
A wrong key state shows at the ports in two ways. A guarded register either ignores a write or takes one it should have refused. Either case is visible on the next read of that address, one cycle after that read. A decode fault shows up as a nonzero value from an unmapped address, or as a stray value in another register. Sweeping every address on read and write exposes either case in the same way. Sweeping all 256 key values makes sure that exactly one value opens the window.

// File: rtl/keyed_bank_pkg.sv
package keyed_bank_pkg;
    localparam int          ADDR_W      = 12;
    localparam int          DATA_W      = 8;
    localparam logic [11:0] PROT_BASE   = 12'h010;
    localparam int          PROT_COUNT  = 6;
    localparam int          PROT_STRIDE = 2;
    localparam logic [11:0] KEY_ADDR    = 12'h020;
    localparam logic [7:0]  KEY_VALUE   = 8'h96;
    localparam logic [11:0] OPEN_BASE   = 12'hC41;
    localparam int          OPEN_COUNT  = 13;
endpackage

// File: rtl/bank_decode.sv
module bank_decode #(
    parameter int              ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] PROT_BASE = 12'h010,
    parameter int              PROT_COUNT  = 6,
    parameter int              PROT_STRIDE = 2,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 12'h020,
    parameter logic [ADDR_W-1:0] OPEN_BASE = 12'hC41,
    parameter int              OPEN_COUNT  = 13,
    parameter int              PIDX_W      = 3,
    parameter int              OIDX_W      = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              key_hit,
    output logic              prot_hit,
    output logic [PIDX_W-1:0] prot_idx,
    output logic              open_hit,
    output logic [OIDX_W-1:0] open_idx
);
    logic [PROT_COUNT-1:0] prot_match;
    logic [ADDR_W-1:0]     open_off;

    for (genvar g = 0; g < PROT_COUNT; g++) begin : g_prot
        assign prot_match[g] = (addr == ADDR_W'(PROT_BASE + g * PROT_STRIDE));
    end

    always_comb begin
        prot_idx = '0;
        for (int i = 0; i < PROT_COUNT; i++) begin
            if (prot_match[i]) prot_idx = PIDX_W'(i);
        end
    end

    assign prot_hit = |prot_match;
    assign key_hit  = (addr == KEY_ADDR);
    assign open_off = addr - OPEN_BASE;
    assign open_hit = (addr >= OPEN_BASE) && (open_off < ADDR_W'(OPEN_COUNT));
    assign open_idx = open_off[OIDX_W-1:0];
endmodule

// File: rtl/bank_key_gate.sv
module bank_key_gate #(
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] KEY_VALUE = 8'h96
) (
    input  logic [DATA_W-1:0] key_q,
    output logic              unlocked
);
    assign unlocked = (key_q == KEY_VALUE);
endmodule

// File: rtl/bank_rdmux.sv
module bank_rdmux #(
    parameter int DATA_W     = 8,
    parameter int PROT_COUNT = 6,
    parameter int OPEN_COUNT = 13,
    parameter int PIDX_W     = 3,
    parameter int OIDX_W     = 4
) (
    input  logic                             key_hit,
    input  logic                             prot_hit,
    input  logic [PIDX_W-1:0]                prot_idx,
    input  logic                             open_hit,
    input  logic [OIDX_W-1:0]                open_idx,
    input  logic [DATA_W-1:0]                key_q,
    input  logic [PROT_COUNT-1:0][DATA_W-1:0] prot_q,
    input  logic [OPEN_COUNT-1:0][DATA_W-1:0] open_q,
    output logic [DATA_W-1:0]                rd_val
);
    always_comb begin
        rd_val = '0;
        if (key_hit)  rd_val = key_q;
        if (prot_hit) rd_val = prot_q[prot_idx];
        if (open_hit) rd_val = open_q[open_idx];
    end
endmodule

// File: rtl/keyed_ctl_bank.sv
module keyed_ctl_bank
    import keyed_bank_pkg::*;
#(
    parameter int                ADDR_W_P    = ADDR_W,
    parameter int                DATA_W_P    = DATA_W,
    parameter int                PROT_COUNT_P = PROT_COUNT,
    parameter int                OPEN_COUNT_P = OPEN_COUNT,
    parameter logic [DATA_W_P-1:0] KEY_VALUE_P = KEY_VALUE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W_P-1:0] addr,
    input  logic [DATA_W_P-1:0] wdata,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [DATA_W_P-1:0] rdata
);
    localparam int PIDX_W = (PROT_COUNT_P > 1) ? $clog2(PROT_COUNT_P) : 1;
    localparam int OIDX_W = (OPEN_COUNT_P > 1) ? $clog2(OPEN_COUNT_P) : 1;

    typedef struct packed {
        logic [PROT_COUNT_P-1:0][DATA_W_P-1:0] prot;
        logic [OPEN_COUNT_P-1:0][DATA_W_P-1:0] open;
        logic [DATA_W_P-1:0]                   key;
        logic [DATA_W_P-1:0]                   rdata;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic                key_hit, prot_hit, open_hit, unlocked;
    logic [PIDX_W-1:0]   prot_idx;
    logic [OIDX_W-1:0]   open_idx;
    logic [DATA_W_P-1:0] rd_val;

    logic [PROT_COUNT_P-1:0][DATA_W_P-1:0] prot_q;
    logic [OPEN_COUNT_P-1:0][DATA_W_P-1:0] open_q;
    logic [DATA_W_P-1:0]                   key_q;

    assign prot_q = st_q.prot;
    assign open_q = st_q.open;
    assign key_q  = st_q.key;
    assign rdata  = st_q.rdata;

    bank_decode #(
        .ADDR_W(ADDR_W_P), .PROT_BASE(ADDR_W_P'(PROT_BASE)),
        .PROT_COUNT(PROT_COUNT_P), .PROT_STRIDE(PROT_STRIDE),
        .KEY_ADDR(ADDR_W_P'(KEY_ADDR)), .OPEN_BASE(ADDR_W_P'(OPEN_BASE)),
        .OPEN_COUNT(OPEN_COUNT_P), .PIDX_W(PIDX_W), .OIDX_W(OIDX_W)
    ) u_decode (
        .addr(addr), .key_hit(key_hit), .prot_hit(prot_hit),
        .prot_idx(prot_idx), .open_hit(open_hit), .open_idx(open_idx)
    );

    bank_key_gate #(.DATA_W(DATA_W_P), .KEY_VALUE(KEY_VALUE_P)) u_gate (
        .key_q(key_q), .unlocked(unlocked)
    );

    bank_rdmux #(
        .DATA_W(DATA_W_P), .PROT_COUNT(PROT_COUNT_P), .OPEN_COUNT(OPEN_COUNT_P),
        .PIDX_W(PIDX_W), .OIDX_W(OIDX_W)
    ) u_rdmux (
        .key_hit(key_hit), .prot_hit(prot_hit), .prot_idx(prot_idx),
        .open_hit(open_hit), .open_idx(open_idx), .key_q(key_q),
        .prot_q(prot_q), .open_q(open_q), .rd_val(rd_val)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = rd_en ? rd_val : '0;
        if (wr_en) begin
            if (key_hit)              st_d.key            = wdata;
            if (prot_hit && unlocked) st_d.prot[prot_idx] = wdata;
            if (open_hit)             st_d.open[open_idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/keyed_ctl_bank_chk.sv
module keyed_ctl_bank_chk #(
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 8,
    parameter int                PROT_COUNT = 6,
    parameter int                OPEN_COUNT = 13,
    parameter logic [DATA_W-1:0] KEY_VALUE  = 8'h96
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [ADDR_W-1:0]                addr,
    input logic [DATA_W-1:0]                wdata,
    input logic                             wr_en,
    input logic                             rd_en,
    input logic [DATA_W-1:0]                rdata,
    input logic [DATA_W-1:0]                key_q,
    input logic [PROT_COUNT-1:0][DATA_W-1:0] prot_q,
    input logic [OPEN_COUNT-1:0][DATA_W-1:0] open_q
);
    localparam logic [ADDR_W-1:0] P_BASE = ADDR_W'(12'h010);
    localparam logic [ADDR_W-1:0] K_ADDR = ADDR_W'(12'h020);
    localparam logic [ADDR_W-1:0] O_BASE = ADDR_W'(12'hC41);

    logic [ADDR_W-1:0] prel, orel;
    logic              is_prot, is_open, is_key, is_unmapped;
    logic [3:0]        pidx;
    logic [3:0]        oidx;

    always_comb begin
        prel        = addr - P_BASE;
        orel        = addr - O_BASE;
        is_prot     = (addr >= P_BASE) && !prel[0] && (prel < ADDR_W'(2 * PROT_COUNT));
        is_open     = (addr >= O_BASE) && (orel < ADDR_W'(OPEN_COUNT));
        is_key      = (addr == K_ADDR);
        is_unmapped = !is_prot && !is_open && !is_key;
        pidx        = prel[4:1];
        oidx        = orel[3:0];
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0); // R2
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && is_unmapped |=> rdata == '0); // R3
    AST_KEY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && is_key |=> key_q == $past(wdata)); // R4
    AST_UNLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && is_prot && key_q == KEY_VALUE |=> prot_q[$past(pidx)] == $past(wdata)); // R5
    AST_LOCKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && is_prot && key_q == KEY_VALUE) |=> $stable(prot_q)); // R6
    AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && is_key) |=> $stable(key_q)); // R7
    AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && is_open |=> open_q[$past(oidx)] == $past(wdata)); // R8
    AST_OPEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && is_open) |=> $stable(open_q)); // R10
endmodule

bind keyed_ctl_bank keyed_ctl_bank_chk #(
    .ADDR_W(ADDR_W_P), .DATA_W(DATA_W_P), .PROT_COUNT(PROT_COUNT_P),
    .OPEN_COUNT(OPEN_COUNT_P), .KEY_VALUE(KEY_VALUE_P)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .key_q(key_q), .prot_q(prot_q), .open_q(open_q)
);

// File: tb/keyed_ctl_bank_test.sv
module keyed_ctl_bank_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_key;
    logic [7:0] m_prot [6];
    logic [7:0] m_open [13];

    keyed_ctl_bank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int prot_slot(input logic [11:0] a);
        if (a >= 12'h010 && a <= 12'h01A && !a[0]) return int'((a - 12'h010) >> 1);
        return -1;
    endfunction

    function automatic int open_slot(input logic [11:0] a);
        if (a >= 12'hC41 && a <= 12'hC4D) return int'(a - 12'hC41);
        return -1;
    endfunction

    function automatic logic [7:0] model_read(input logic [11:0] a);
        if (a == 12'h020) return m_key;
        if (prot_slot(a) >= 0) return m_prot[prot_slot(a)];
        if (open_slot(a) >= 0) return m_open[open_slot(a)];
        return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [11:0] a,
                         input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, a, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 12'h020) m_key = d;
        else if (prot_slot(a) >= 0 && m_key == 8'h96) m_prot[prot_slot(a)] = d;
        else if (open_slot(a) >= 0) m_open[open_slot(a)] = d;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        m_key = '0;
        for (int i = 0; i < 6; i++) m_prot[i] = '0;
        for (int i = 0; i < 13; i++) m_open[i] = '0;

        repeat (3) @(negedge clk);
        check("R1 rdata in reset", 12'h0, rdata, 8'h00);
        rst_n = 1'b1;

        // R1 R3: full read sweep after reset, all zero
        for (int a = 0; a < 4096; a++) begin
            bus_read(12'(a), v);
            check("R1 R3 reset sweep", 12'(a), v, 8'h00);
        end

        // R6: locked writes to guarded registers are dropped
        for (int i = 0; i < 6; i++) bus_write(12'h010 + 12'(2 * i), 8'hA0 + 8'(i));
        for (int i = 0; i < 6; i++) begin
            bus_read(12'h010 + 12'(2 * i), v);
            check("R6 locked write dropped", 12'h010 + 12'(2 * i), v, 8'h00);
        end

        // R4 R5 R7: unlock, write all guarded regs, stays unlocked across them
        bus_write(12'h020, 8'h96);
        bus_read(12'h020, v);
        check("R4 key readback", 12'h020, v, 8'h96);
        for (int i = 0; i < 6; i++) bus_write(12'h010 + 12'(2 * i), 8'h31 * 8'(i + 1));
        for (int i = 0; i < 6; i++) begin
            bus_read(12'h010 + 12'(2 * i), v);
            check("R5 R7 unlocked write", 12'h010 + 12'(2 * i), v, 8'h31 * 8'(i + 1));
        end

        // R5 R6 R7 R4: sweep every key value, try a guarded write each time
        for (int k = 0; k < 256; k++) begin
            bus_write(12'h020, 8'(k));
            bus_read(12'h020, v);
            check("R4 key sweep readback", 12'h020, v, 8'(k));
            bus_write(12'h014, 8'(k) ^ 8'h5A);
            bus_read(12'h014, v);
            check("R5 R6 R7 key sweep gate", 12'h014, v, model_read(12'h014));
        end
        check("R7 relocked after sweep", 12'h020, m_key, 8'hFF);

        // R8: open window writable while locked
        for (int i = 0; i < 13; i++) bus_write(12'hC41 + 12'(i), 8'hC0 ^ 8'(i * 7));
        for (int i = 0; i < 13; i++) begin
            bus_read(12'hC41 + 12'(i), v);
            check("R8 open window locked", 12'hC41 + 12'(i), v, 8'hC0 ^ 8'(i * 7));
        end

        // R2: same-cycle write and read returns the old value, idle gives zero
        bus_write(12'h020, 8'h96);
        @(negedge clk);
        addr = 12'h018; wdata = 8'h77; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R2 read before same-cycle write", 12'h018, rdata, m_prot[4]);
        m_prot[4] = 8'h77;
        @(negedge clk);
        check("R2 idle rdata zero", 12'h018, rdata, 8'h00);
        bus_read(12'h018, v);
        check("R2 read after write", 12'h018, v, 8'h77);

        // R10: writes to every unmapped address, window open, change nothing
        for (int a = 0; a < 4096; a++) begin
            if (12'(a) != 12'h020 && prot_slot(12'(a)) < 0 && open_slot(12'(a)) < 0)
                bus_write(12'(a), 8'hFF);
        end
        // R9 R3 R10: full read sweep against the model, window open then closed
        for (int a = 0; a < 4096; a++) begin
            bus_read(12'(a), v);
            check("R3 R9 R10 sweep unlocked", 12'(a), v, model_read(12'(a)));
        end
        bus_write(12'h020, 8'h00);
        for (int a = 0; a < 64; a++) begin
            bus_read(12'(a), v);
            check("R9 sweep locked", 12'(a), v, model_read(12'(a)));
        end
        for (int i = 0; i < 13; i++) begin
            bus_read(12'hC41 + 12'(i), v);
            check("R9 open locked read", 12'hC41 + 12'(i), v, m_open[i]);
        end

        finish_run();
    end
endmodule